// File: doc/BRIEF.md
# Parity-Preserving Reversible Gate Set

This block models four small reversible logic gates. Each one maps an input vector to an output vector of the same width, one to one. Every gate also keeps the XOR of its inputs equal to the XOR of its outputs. The set has three 3-bit gates and one 4-bit gate:

- a fan-out gate that XORs its first input into the other two;
- a controlled exchange, where the first input decides whether the other two trade places;
- a fault-tolerant mixing gate;
- a 4-bit gate that combines pass-through, XOR and AND terms.

All four gates evaluate in parallel on the same input vector. A select input picks which result reaches the outputs. The whole block is combinational and has no state.

Each gate has its own parity comparator. The comparator XORs the gate's live inputs and its delivered outputs, and raises a fault flag when the two parities differ. A fault-injection control can invert one chosen output bit after the gate logic. This lets the comparator be exercised: one wrong bit changes the output parity, so it must always be flagged.

Top module: `pp_gate_lib`

## Requirements
- R1: With `gate_sel` = 0 (fan-out gate), using bit order A=`vec_in[0]`, B=`vec_in[1]`, C=`vec_in[2]` and P=`vec_out[0]`, Q=`vec_out[1]`, R=`vec_out[2]`, the outputs are P=A, Q=A^B and R=A^C.
- R2: With `gate_sel` = 1 (controlled exchange), P=A. When A=0, Q=B and R=C; when A=1, Q=C and R=B. Input A=1,B=0,C=1 gives P=1,Q=1,R=0.
- R3: With `gate_sel` = 2 (mixing gate), P=A^B, Q=(A&~C)^(~B&C) and R=(A&~C)^(B&C).
- R4: With `gate_sel` = 3 (4-bit gate), with D=`vec_in[3]` and S=`vec_out[3]`, the outputs are P=A, Q=A^B, R=(A&B)^C and S=(A&~B)^D.
- R5: Over the live inputs of a gate (8 values for 3-bit gates, 16 for the 4-bit gate), no two input values give the same output.
- R6: With `flip_en` low, the XOR of the output bits equals the XOR of the live input bits, and `fault` is low.
- R7: With `flip_en` high and `flip_idx` naming a live output bit, exactly that bit of the correct result is inverted, and `fault` is high.
- R8: For the 3-bit gates, `vec_in[3]` has no effect and `vec_out[3]` is 0. A flip aimed at index 3 is dropped: the output stays correct and `fault` stays low.
- R9: An all-zero input with no injection gives an all-zero output and a low `fault` for every gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gate_sel | input | 2 | Gate choice: 0 fan-out, 1 controlled exchange, 2 mixing, 3 four-bit |
| vec_in | input | 4 | Input vector; bit 0 is A, bit 3 is D |
| flip_en | input | 1 | Enables inversion of one output bit |
| flip_idx | input | 2 | Index of the output bit to invert |
| vec_out | output | 4 | Output vector of the selected gate; bit 0 is P, bit 3 is S |
| fault | output | 1 | High when output parity differs from input parity |

## Verification
The block holds no state, so any fault inside it shows at the ports in the same evaluation as the stimulus that exposes it.

- A wrong product term in one gate changes `vec_out` for only a few input values. The exhaustive sweep of every gate compares all of them.
- A term that breaks reversibility makes two inputs share one output, which the per-gate seen-set catches.
- A comparator that misses a bit, or a flip that lands on the wrong index, shows up as a `fault` level or output bit that disagrees with the single-flip expectation. This is checked for every input and every index.

// File: rtl/pp_gate_pkg.sv
package pp_gate_pkg;

    localparam int VEC_W     = 4;
    localparam int IDX_W     = $clog2(VEC_W);
    localparam int NUM_KINDS = 4;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        GK_DFAN  = 2'd0,
        GK_CSWAP = 2'd1,
        GK_NFT   = 2'd2,
        GK_MIG4  = 2'd3
    } gate_kind_e;

    typedef struct packed {
        vec_t data;
        logic fault;
    } gate_res_t;

    function automatic int kind_width(gate_kind_e k);
        return (k == GK_MIG4) ? 4 : 3;
    endfunction

    function automatic vec_t width_mask(gate_kind_e k);
        vec_t m;
        m = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (i < kind_width(k)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic vec_t gate_map(gate_kind_e k, vec_t v);
        logic a, b, c, d;
        vec_t r;
        a = v[0];
        b = v[1];
        c = v[2];
        d = v[3];
        r = '0;
        case (k)
            GK_DFAN: begin
                r[0] = a;
                r[1] = a ^ b;
                r[2] = a ^ c;
            end
            GK_CSWAP: begin
                r[0] = a;
                r[1] = (~a & b) ^ (a & c);
                r[2] = (~a & c) ^ (a & b);
            end
            GK_NFT: begin
                r[0] = a ^ b;
                r[1] = (a & ~c) ^ (~b & c);
                r[2] = (a & ~c) ^ (b & c);
            end
            default: begin
                r[0] = a;
                r[1] = a ^ b;
                r[2] = (a & b) ^ c;
                r[3] = (a & ~b) ^ d;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pp_parity_chk.sv
module pp_parity_chk #(
    parameter int W = 4
) (
    input  logic [W-1:0] side_in,
    input  logic [W-1:0] side_out,
    output logic         mismatch
);
    logic par_in;
    logic par_out;

    always_comb begin
        par_in   = ^side_in;
        par_out  = ^side_out;
        mismatch = par_in ^ par_out;
    end
endmodule

// File: rtl/pp_gate.sv
module pp_gate
    import pp_gate_pkg::*;
#(
    parameter gate_kind_e KIND = GK_DFAN
) (
    input  vec_t      vin,
    input  vec_t      flip,
    output gate_res_t res
);
    localparam vec_t LIVE = width_mask(KIND);

    vec_t in_eff;
    vec_t flip_eff;
    vec_t ideal;
    vec_t delivered;
    logic mism;

    always_comb begin
        in_eff    = vin & LIVE;
        flip_eff  = flip & LIVE;
        ideal     = gate_map(KIND, in_eff) & LIVE;
        delivered = ideal ^ flip_eff;
    end

    pp_parity_chk #(.W(VEC_W)) u_chk (
        .side_in  (in_eff),
        .side_out (delivered),
        .mismatch (mism)
    );

    assign res.data  = delivered;
    assign res.fault = mism;

    // R6: no injected flip means the comparator stays quiet
    always_comb begin
        if (!$isunknown({vin, flip}) && flip_eff == '0)
            a_r6_clean_parity: assert (!res.fault)
                else $error("gate %0d flagged without injection", KIND);
    end

    // R7: a single injected flip must be caught by the comparator
    always_comb begin
        if (!$isunknown({vin, flip}) && $countones(flip_eff) == 1)
            a_r7_flip_seen: assert (res.fault)
                else $error("gate %0d missed a single flip", KIND);
    end
endmodule

// File: rtl/pp_gate_lib.sv
module pp_gate_lib
    import pp_gate_pkg::*;
(
    input  logic [1:0]       gate_sel,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_idx,
    output logic [VEC_W-1:0] vec_out,
    output logic             fault
);
    vec_t      flip_vec;
    gate_res_t res_all [NUM_KINDS];

    always_comb begin
        flip_vec = '0;
        if (flip_en) flip_vec[flip_idx] = 1'b1;
    end

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_gate
        pp_gate #(.KIND(gate_kind_e'(g))) u_gate (
            .vin  (vec_in),
            .flip (flip_vec),
            .res  (res_all[g])
        );
    end

    always_comb begin
        vec_out = res_all[gate_sel].data;
        fault   = res_all[gate_sel].fault;
    end

    // R8: narrow gates never drive the top bit
    always_comb begin
        if (!$isunknown({gate_sel, vec_in, flip_en, flip_idx}) &&
            gate_sel != GK_MIG4)
            a_r8_pad_zero: assert (vec_out[3] == 1'b0)
                else $error("narrow gate drove bit 3");
    end

    // R2: the controlled exchange conserves the number of ones
    always_comb begin
        if (!$isunknown({gate_sel, vec_in, flip_en, flip_idx}) &&
            gate_sel == GK_CSWAP && !flip_en)
            a_r2_conserve: assert ($countones(vec_out[2:0]) == $countones(vec_in[2:0]))
                else $error("controlled exchange changed ones count");
    end
endmodule

// File: tb/pp_gate_lib_test.sv
`timescale 1ns/1ps
module pp_gate_lib_test;
    logic       clk = 1'b0;
    logic [1:0] gate_sel = '0;
    logic [3:0] vec_in = '0;
    logic       flip_en = 1'b0;
    logic [1:0] flip_idx = '0;
    logic [3:0] vec_out;
    logic       fault;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pp_gate_lib uut (
        .gate_sel (gate_sel),
        .vec_in   (vec_in),
        .flip_en  (flip_en),
        .flip_idx (flip_idx),
        .vec_out  (vec_out),
        .fault    (fault)
    );

    function automatic int ref_w(int k);
        return (k == 3) ? 4 : 3;
    endfunction

    function automatic logic [3:0] ref_map(int k, logic [3:0] v);
        logic [3:0] o;
        logic a, b, c, d;
        {d, c, b, a} = v;
        o = 4'b0;
        if (k == 0) begin
            o = {1'b0, (c != a), (b != a), a};
        end else if (k == 1) begin
            o = a ? {1'b0, b, c, a} : {1'b0, c, b, a};
        end else if (k == 2) begin
            o[0] = (a != b);
            o[1] = c ? ~b : a;
            o[2] = c ? b : a;
        end else begin
            o[0] = a;
            o[1] = (a != b);
            o[2] = a ? (b != c) : c;
            o[3] = a ? (b == d) : d;
        end
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [4:0] act,
                       input logic [4:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s sel=%0d in=%b flip=%b/%0d act={out,fault}=%b exp=%b",
                     req, gate_sel, vec_in, flip_en, flip_idx, act, exp);
        end
    endtask

    task automatic drive(input int k, input int v, input bit fe, input int fi);
        @(negedge clk);
        gate_sel = 2'(k);
        vec_in   = 4'(v);
        flip_en  = fe;
        flip_idx = 2'(fi);
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string rname [4];
        rname[0] = "R1";
        rname[1] = "R2";
        rname[2] = "R3";
        rname[3] = "R4";

        // R9: zero vector through every gate
        for (int k = 0; k < 4; k++) begin
            drive(k, 0, 0, 0);
            chk(vec_out == 4'b0 && fault == 1'b0, "R9",
                {vec_out, fault}, 5'b0);
        end

        // R2: the documented example
        drive(1, 4'b0101, 0, 0);
        chk(vec_out == 4'b0011 && !fault, "R2",
            {vec_out, fault}, {4'b0011, 1'b0});

        for (int k = 0; k < 4; k++) begin
            bit seen [16];
            for (int i = 0; i < 16; i++) seen[i] = 0;
            for (int v = 0; v < 16; v++) begin
                logic [3:0] live;
                logic [3:0] exp;
                live = (ref_w(k) == 4) ? 4'(v) : 4'(v & 7);
                exp  = ref_map(k, live);

                // mapping, R1..R4 (and R8 for narrow gates with bit 3 set)
                drive(k, v, 0, 0);
                chk(vec_out == exp && !fault, (v >= 8 && k != 3) ? "R8" : rname[k],
                    {vec_out, fault}, {exp, 1'b0});

                // R6: parity equality at the ports
                chk((^vec_out) == (^live) && !fault, "R6",
                    {vec_out, fault}, {exp, 1'b0});

                // R5: distinct outputs over live inputs
                if (v < (1 << ref_w(k))) begin
                    chk(!seen[vec_out], "R5", {vec_out, fault}, {exp, 1'b0});
                    seen[vec_out] = 1;
                end

                // R7 / R8: single flip on each index
                for (int fi = 0; fi < 4; fi++) begin
                    logic [3:0] fexp;
                    bit         ffl;
                    if (fi < ref_w(k)) begin
                        fexp = exp ^ (4'b1 << fi);
                        ffl  = 1;
                    end else begin
                        fexp = exp;
                        ffl  = 0;
                    end
                    drive(k, v, 1, fi);
                    chk(vec_out == fexp && fault == ffl, ffl ? "R7" : "R8",
                        {vec_out, fault}, {fexp, ffl});
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule